// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block joins two eight-input interrupt controller cores into one fifteen-line interrupt source for a processor. The secondary core's request output takes the place of input 2 of the primary core. The processor therefore sees a single interrupt request line and a single acknowledge strobe. Every core keeps its own mask and in-service registers and runs fully nested priority: a request is raised only when its line outranks every line already in service on that core.

Software reaches the two cores through a 16-bit I/O write port. The primary core answers at 0x20/0x21 and the secondary at 0xA0/0xA1. Address bit 0 chooses between the command register (bit 0 = 0) and the mask register (bit 0 = 1). On an acknowledge, the core that owns the winning line marks it in service. The vector comes back one cycle later. When the winner is the cascade slot, the vector is the secondary core's; in every other case it is the primary core's.

Top module: `cascade_pic`

## Requirements
- R1: The primary core is selected only when io_addr[15:1] = 0x10, with io_addr[0] as its register select. A write to any other address leaves the primary core unchanged.
- R2: The secondary core is selected only when io_addr[15:1] = 0x50 (ports 0xA0/0xA1), with io_addr[0] as its register select.
- R3: int_out is high while some unmasked request outranks every in-service line of its core. An int_ack cycle in which int_out is high marks the winning line in service. On the next cycle vec_vld is high for exactly one cycle.
- R4: Combined priority from highest to lowest is: primary 0, primary 1, secondary 0..7, then primary 3..7. On each core, a lower index ranks higher.
- R5: Primary line n returns vector 0x20+n and secondary line n returns 0x28+n. irq_m bits 0,1 are primary lines 0,1, and irq_m bits 2..6 are primary lines 3..7.
- R6: Writing a byte with register select 1 loads that core's mask. A mask bit of 1 blocks the matching line, and mask bit 2 of the primary core blocks every secondary line.
- R7: Writing 0x20 with register select 0 clears the highest-ranked in-service bit of that core. Any other data byte written with register select 0 has no effect.
- R8: A pending secondary request is held off while primary line 0 or 1 is in service, and it preempts a handler for primary line 3.
- R9: After a secondary-sourced interrupt, no further secondary-sourced interrupt is reported until both the secondary core and the primary core have received an end-of-interrupt.
- R10: After reset, int_out and vec_vld are low and both mask registers are clear.
- R11: An int_ack while int_out is low changes nothing, and vec_vld stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_m | input | 7 | Primary device requests (bits 0,1 = lines 0,1; bits 2..6 = lines 3..7), level sensitive |
| irq_s | input | 8 | Secondary device requests, lines 0..7, level sensitive |
| io_addr | input | 16 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| int_ack | input | 1 | Processor acknowledge strobe |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector of the last acknowledged interrupt |
| vec_vld | output | 1 | One-cycle pulse, the cycle after an accepted acknowledge |

## Verification
Directed cases put one secondary line and primary line 3 up at the same moment; this shows the interleaved order apart from a flat 0..15 ranking. Held-off and preemption cases nest secondary requests under primary lines 1 and 3. Sequences that retire one core at a time show the two-step end-of-interrupt rule apart from a one-step one. Writes to near-miss addresses, non-command data bytes and masks show where the decoder stops and which register a write reaches. A seeded random phase then mixes sparse request levels, acknowledges, end-of-interrupt writes, mask loads and stray writes against a reference model of both cores; this reaches nesting depths that the directed cases never reach.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
    localparam int          CORE_LINES = 8;
    localparam int          CORE_IW    = $clog2(CORE_LINES);
    localparam logic [7:0]  CMD_EOI    = 8'h20;

    typedef struct packed {
        logic [7:0] vec;
        logic       vld;
    } vec_state_t;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/pic_addr_dec.sv
module pic_addr_dec #(
    parameter logic [15:0] MST_PORT = 16'h0020,
    parameter logic [15:0] SLV_PORT = 16'h00A0
) (
    input  logic [15:0] addr,
    input  logic        wr,
    output logic        mst_wr,
    output logic        slv_wr,
    output logic        reg_sel
);
    logic cs_mst, cs_slv;

    always_comb begin
        cs_mst  = (addr[15:1] == MST_PORT[15:1]);
        cs_slv  = (addr[15:1] == SLV_PORT[15:1]);
        mst_wr  = wr && cs_mst;
        slv_wr  = wr && cs_slv;
        reg_sel = addr[0];
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import cpic_pkg::*;
#(
    parameter int         NUM_IN   = CORE_LINES,
    parameter logic [7:0] VEC_BASE = 8'h20,
    localparam int        IW       = $clog2(NUM_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] req,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [7:0]        wr_data,
    input  logic              ack,
    output logic              intr,
    output logic [IW-1:0]     grant,
    output logic [7:0]        vector
);
    typedef struct packed {
        logic [NUM_IN-1:0] imr;
        logic [NUM_IN-1:0] isr;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [NUM_IN-1:0] pend;
    logic              pend_found, serv_found;
    logic [IW-1:0]     pend_idx, serv_idx;
    logic              eoi_cmd;

    assign pend = req & ~st_q.imr;

    pic_prio #(.N(NUM_IN)) u_pend_prio (.vec(pend),     .found(pend_found), .idx(pend_idx));
    pic_prio #(.N(NUM_IN)) u_serv_prio (.vec(st_q.isr), .found(serv_found), .idx(serv_idx));

    always_comb begin
        st_d    = st_q;
        intr    = pend_found && (!serv_found || (pend_idx < serv_idx));
        grant   = pend_idx;
        vector  = VEC_BASE + 8'(pend_idx);
        eoi_cmd = wr_en && !wr_sel && (wr_data == CMD_EOI);

        if (wr_en && wr_sel) st_d.imr = wr_data[NUM_IN-1:0];
        if (eoi_cmd && serv_found) st_d.isr[serv_idx] = 1'b0;
        if (ack && intr) st_d.isr[pend_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && intr) |=> st_q.isr[$past(pend_idx)]); // R3

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_cmd && serv_found && !(ack && intr)) |=>
        ($countones(st_q.isr) + 1 == $countones($past(st_q.isr)))); // R7

    AST_TOP_SERVICE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.isr[0] |-> !intr); // R8
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
    import cpic_pkg::*;
#(
    parameter logic [15:0] MST_PORT = 16'h0020,
    parameter logic [15:0] SLV_PORT = 16'h00A0,
    parameter logic [7:0]  MST_VEC  = 8'h20,
    parameter logic [7:0]  SLV_VEC  = 8'h28,
    parameter int          CASC_IN  = 2,
    localparam int         IW       = CORE_IW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CORE_LINES-2:0] irq_m,
    input  logic [CORE_LINES-1:0] irq_s,
    input  logic [15:0]           io_addr,
    input  logic [7:0]            io_wdata,
    input  logic                  io_wr,
    input  logic                  int_ack,
    output logic                  int_out,
    output logic [7:0]            vec_out,
    output logic                  vec_vld
);
    vec_state_t vs_d, vs_q;

    logic                  mst_wr, slv_wr, reg_sel;
    logic [CORE_LINES-1:0] m_req;
    logic                  m_intr, s_intr, s_ack;
    logic [IW-1:0]         m_grant, s_grant;
    logic [7:0]            m_vec, s_vec;

    pic_addr_dec #(.MST_PORT(MST_PORT), .SLV_PORT(SLV_PORT)) u_dec (
        .addr(io_addr), .wr(io_wr),
        .mst_wr(mst_wr), .slv_wr(slv_wr), .reg_sel(reg_sel)
    );

    for (genvar g = 0; g < CORE_LINES; g++) begin : g_mreq
        if (g < CASC_IN) begin : g_low
            assign m_req[g] = irq_m[g];
        end else if (g == CASC_IN) begin : g_casc
            assign m_req[g] = s_intr;
        end else begin : g_high
            assign m_req[g] = irq_m[g-1];
        end
    end

    assign s_ack = int_ack && m_intr && (m_grant == IW'(CASC_IN));

    pic_core #(.NUM_IN(CORE_LINES), .VEC_BASE(MST_VEC)) u_mst (
        .clk(clk), .rst_n(rst_n), .req(m_req),
        .wr_en(mst_wr), .wr_sel(reg_sel), .wr_data(io_wdata),
        .ack(int_ack), .intr(m_intr), .grant(m_grant), .vector(m_vec)
    );

    pic_core #(.NUM_IN(CORE_LINES), .VEC_BASE(SLV_VEC)) u_slv (
        .clk(clk), .rst_n(rst_n), .req(irq_s),
        .wr_en(slv_wr), .wr_sel(reg_sel), .wr_data(io_wdata),
        .ack(s_ack), .intr(s_intr), .grant(s_grant), .vector(s_vec)
    );

    always_comb begin
        vs_d     = vs_q;
        vs_d.vld = 1'b0;
        if (int_ack && m_intr) begin
            vs_d.vld = 1'b1;
            vs_d.vec = (m_grant == IW'(CASC_IN)) ? s_vec : m_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vs_q <= '0;
        else        vs_q <= vs_d;
    end

    assign int_out = m_intr;
    assign vec_out = vs_q.vec;
    assign vec_vld = vs_q.vld;

    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> (vec_out[7:4] == MST_VEC[7:4])); // R5

    AST_SLAVE_OWNS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_vld && vec_out[3]) |-> ($past(m_grant) == IW'(CASC_IN))); // R5

    AST_CASC_ACK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        s_ack |-> s_intr); // R3

    AST_WR_ONE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mst_wr && slv_wr)); // R1
endmodule

// File: tb/test_cascade_pic.sv
`timescale 1ns/1ps
module test_cascade_pic;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic [6:0]  irq_m = '0;
    logic [7:0]  irq_s = '0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0, int_ack = 1'b0;
    logic        int_out, vec_vld;
    logic [7:0]  vec_out;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit [7:0] mi_isr, mi_imr, sl_isr, sl_imr;

    cascade_pic i_cascade_pic (
        .clk(clk), .rst_n(rst_n), .irq_m(irq_m), .irq_s(irq_s),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_wr(io_wr),
        .int_ack(int_ack), .int_out(int_out), .vec_out(vec_out), .vec_vld(vec_vld)
    );

    always #4 clk = ~clk;

    function automatic int top_idx(bit [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic int slv_hp();
        return top_idx(irq_s & ~sl_imr);
    endfunction

    function automatic bit slv_int();
        int hp = slv_hp();
        return (hp < 8) && (hp < top_idx(sl_isr));
    endfunction

    function automatic bit [7:0] mst_req();
        return {irq_m[6:2], slv_int(), irq_m[1:0]};
    endfunction

    function automatic int mst_hp();
        return top_idx(mst_req() & ~mi_imr);
    endfunction

    function automatic bit exp_int();
        int hp = mst_hp();
        return (hp < 8) && (hp < top_idx(mi_isr));
    endfunction

    function automatic int exp_vec();
        int hp = mst_hp();
        return (hp == 2) ? (8'h28 + slv_hp()) : (8'h20 + hp);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_irq(bit [6:0] m, bit [7:0] s);
        irq_m = m;
        irq_s = s;
        #1;
    endtask

    task automatic chk_int(bit expv, string req);
        check(int_out == expv, req, "int_out", int_out, expv);
    endtask

    task automatic do_ack(output int v);
        bit e_int = exp_int();
        int ev = exp_vec();
        int mh = mst_hp();
        int sh = slv_hp();
        check(int_out == e_int, "R3", "int_out before ack", int_out, e_int);
        if (e_int) begin
            mi_isr[mh] = 1'b1;
            if (mh == 2) sl_isr[sh] = 1'b1;
        end
        int_ack = 1'b1;
        cyc();
        int_ack = 1'b0;
        #1;
        check(vec_vld == e_int, e_int ? "R3" : "R11", "vec_vld", vec_vld, e_int);
        if (e_int) check(vec_out == ev[7:0], "R5", "vec_out", vec_out, ev);
        v = vec_vld ? int'(vec_out) : -1;
        cyc();
        check(vec_vld == 1'b0, "R3", "vec_vld pulse length", vec_vld, 0);
    endtask

    task automatic wr(bit [15:0] a, bit [7:0] d);
        int k;
        if (a[15:1] == 15'h10) begin
            if (a[0]) mi_imr = d;
            else if (d == 8'h20) begin k = top_idx(mi_isr); if (k < 8) mi_isr[k] = 1'b0; end
        end
        if (a[15:1] == 15'h50) begin
            if (a[0]) sl_imr = d;
            else if (d == 8'h20) begin k = top_idx(sl_isr); if (k < 8) sl_isr[k] = 1'b0; end
        end
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        cyc();
        io_wr = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL all watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'd20240611));
        mi_isr = '0; mi_imr = '0; sl_isr = '0; sl_imr = '0;
        repeat (3) cyc();
        check(int_out == 1'b0, "R10", "int_out in reset", int_out, 0);
        check(vec_vld == 1'b0, "R10", "vec_vld in reset", vec_vld, 0);
        rst_n = 1'b1;
        cyc();

        // R10: masks clear after reset, any line is reported
        set_irq(7'h00, 8'h80);
        chk_int(1'b1, "R10");
        set_irq(7'h00, 8'h00);

        // R4: secondary 5 against primary 3
        set_irq(7'h04, 8'h20);
        chk_int(1'b1, "R4");
        do_ack(v);
        check(v == 8'h2D, "R4", "slave beats m3", v, 8'h2D);
        chk_int(1'b0, "R9");
        wr(16'h00A0, 8'h20);
        chk_int(1'b0, "R9");        // primary slot 2 still in service
        wr(16'h0020, 8'h20);
        chk_int(1'b1, "R9");
        do_ack(v);
        check(v == 8'h2D, "R9", "slave again after both eoi", v, 8'h2D);
        set_irq(7'h04, 8'h00);
        wr(16'h00A0, 8'h20);
        wr(16'h0020, 8'h20);
        do_ack(v);
        check(v == 8'h23, "R5", "m3 vector", v, 8'h23);

        // R8: secondary preempts primary 3 handler
        set_irq(7'h04, 8'h02);
        chk_int(1'b1, "R8");
        do_ack(v);
        check(v == 8'h29, "R8", "preempt m3", v, 8'h29);
        wr(16'h00A0, 8'h20);
        wr(16'h0020, 8'h20);
        set_irq(7'h00, 8'h00);
        wr(16'h0020, 8'h20);
        chk_int(1'b0, "R7");

        // R8: held off under primary 1
        set_irq(7'h02, 8'h00);
        do_ack(v);
        check(v == 8'h21, "R5", "m1 vector", v, 8'h21);
        set_irq(7'h00, 8'h01);
        chk_int(1'b0, "R8");
        wr(16'h0020, 8'h20);
        chk_int(1'b1, "R8");
        do_ack(v);
        check(v == 8'h28, "R8", "s0 after m1 eoi", v, 8'h28);
        set_irq(7'h00, 8'h00);
        wr(16'h00A0, 8'h20);
        wr(16'h0020, 8'h20);

        // R1, R7: decode and command data
        set_irq(7'h01, 8'h00);
        do_ack(v);
        check(v == 8'h20, "R5", "m0 vector", v, 8'h20);
        chk_int(1'b0, "R8");
        wr(16'h0120, 8'h20);
        chk_int(1'b0, "R1");
        wr(16'h0022, 8'h20);
        chk_int(1'b0, "R1");
        wr(16'h0020, 8'h00);
        chk_int(1'b0, "R7");
        wr(16'h0020, 8'h20);
        chk_int(1'b1, "R1");
        set_irq(7'h00, 8'h00);
        wr(16'h0020, 8'h20);

        // R6, R2: masks
        wr(16'h0021, 8'h01);
        set_irq(7'h01, 8'h00);
        chk_int(1'b0, "R6");
        set_irq(7'h00, 8'h08);
        wr(16'h00A1, 8'hFF);
        chk_int(1'b0, "R2");
        wr(16'h00A1, 8'h00);
        chk_int(1'b1, "R2");
        wr(16'h0021, 8'h04);
        chk_int(1'b0, "R6");
        wr(16'h0021, 8'h00);
        do_ack(v);
        check(v == 8'h2B, "R2", "s3 vector", v, 8'h2B);
        set_irq(7'h00, 8'h00);
        wr(16'h00A0, 8'h20);
        wr(16'h0020, 8'h20);

        // R11: acknowledge with nothing pending
        chk_int(1'b0, "R11");
        do_ack(v);
        check(v == -1, "R11", "no vector", v, -1);

        // random phase
        for (int it = 0; it < 4000; it++) begin
            int r = $urandom % 16;
            if (r < 3) begin
                set_irq(7'($urandom & $urandom), 8'($urandom & $urandom & $urandom));
            end else if (r < 8) begin
                do_ack(v);
            end else if (r < 10) begin
                wr(16'h0020, 8'h20);
            end else if (r < 12) begin
                wr(16'h00A0, 8'h20);
            end else if (r == 12) begin
                bit [15:0] a = 16'($urandom);
                if (a[15:1] == 15'h10 || a[15:1] == 15'h50) a[8] = ~a[8];
                wr(a, 8'h20);
            end else if (r == 13) begin
                wr(($urandom % 2) ? 16'h0021 : 16'h00A1, 8'($urandom & $urandom & $urandom));
            end else if (r == 14) begin
                wr(16'h0021, 8'h00);
                wr(16'h00A1, 8'h00);
            end else begin
                cyc();
                #1;
            end
            chk_int(exp_int(), "R4");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule